// File: doc/BRIEF.md
# Isochronous Transfer Buffer Address Generator

This block produces the byte address for one isochronous transfer of a USB host controller. A descriptor supplies eight transaction slots, each with an active bit, a page selector, a 12-bit byte offset and a 12-bit length. It also supplies seven page base pointers. The low three bits of the frame index pick the slot. A start strobe loads the slot's first address: the selected pointer forms the upper 20 bits and the slot offset forms the lower 12 bits.

Each advance strobe marks one byte as moved. The block then steps the offset. When the offset passes the last byte of a 4 KB page, it moves on to the next page pointer. It raises a done flag when the slot's byte count is reached. It raises an error flag when a transfer would need a page beyond the last pointer, and it never folds back to pointer 0. Fetching descriptors, walking the schedule and driving the bus are left to the logic around the block.

Top module: `iso_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high) clears the active, done and error flags. It also clears the page index and offset, so `addr` then equals `{pointer 0, 12'h000}`.
- R2: The slot is chosen only by `frameIdx[2:0]`. The upper frame index bits have no effect.
- R3: A start strobe on an active slot whose page selector is 0..6 sets the active flag and clears done and error. On the clock edge that samples the strobe, it loads `addr = {pagePtr[sel], offset}`. Pointer i occupies `pagePtr[20*i +: 20]`. Slot k uses `slotPage[3*k +: 3]`, `slotOffset[12*k +: 12]`, `slotLen[12*k +: 12]` and `slotActive[k]`.
- R4: While the transfer is active and the strobe is not its last byte, each advance strobe raises the offset by one within the page.
- R5: An advance strobe taken at offset 12'hFFF sets the offset to 0 and moves to the next pointer index on that same edge.
- R6: An advance strobe that would move past pointer 6 sets the error flag and clears the active flag. The address stays at `{pointer 6, 12'hFFF}` and does not alias to pointer 0.
- R7: A start strobe on a slot whose active bit is 0 is ignored. Flags and address keep their values.
- R8: A start strobe on an active slot whose page selector is 7 sets the error flag and leaves the active flag low.
- R9: The advance strobe that moves byte number `len` sets done and clears active. The address holds on the last byte. Later advance strobes change nothing.
- R10: Starting a slot whose length is 0 sets done at once and leaves the active flag low.
- R11: Advance strobes given while no transfer is active leave flags and address unchanged.
- R12: A new start strobe on an active, valid slot clears a previous done or error and restarts from the new slot's start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameIdx | input | 11 | Frame index; bits [2:0] select the slot |
| slotActive | input | 8 | Active bit per slot |
| slotPage | input | 24 | 3-bit page selector per slot |
| slotOffset | input | 96 | 12-bit start offset per slot |
| slotLen | input | 96 | 12-bit byte count per slot |
| pagePtr | input | 140 | Seven 20-bit page base pointers |
| startReq | input | 1 | Start strobe; loads the selected slot |
| advance | input | 1 | One byte moved strobe |
| addr | output | 32 | Current buffer byte address |
| xferActive | output | 1 | Transfer in progress |
| xferDone | output | 1 | Slot length reached |
| xferError | output | 1 | Page overrun or invalid page selector |

## Verification
The bench places one slot two bytes before a page end and checks that the byte after 12'hFFF lands at offset 0 of the next pointer. A design that carried the overflow into the pointer bits, or switched pages one strobe late, would show a wrong upper field. A slot on pointer 6 runs into its page end to confirm the error flag and the held address. A design that aliased to pointer 0 would report pointer 0's base with no error. Other checks cover a zero-length slot, an inactive slot started in the middle of a transfer, a page selector of 7, and advance strobes after done. Each of these exposes designs that count past the length or let a start on an inactive slot clobber state.

// File: rtl/iso_addr_pkg.sv
package iso_addr_pkg;
  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic load;  // capture the selected slot's start address
    logic step;  // move one byte forward, crossing pages as needed
  } ctrlStrb_t;
endpackage

// File: rtl/iso_addr_path.sv
module iso_addr_path
  import iso_addr_pkg::*;
#(
  parameter int FRAME_W   = 11,
  parameter int SLOT_W    = 3,
  parameter int NUM_PAGES = 7,
  parameter int PSEL_W    = 3,
  parameter int OFF_W     = 12,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 32,
  localparam int NUM_SLOTS = 1 << SLOT_W,
  localparam int PTR_W     = ADDR_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [FRAME_W-1:0]           frameIdx,
  input  logic [NUM_SLOTS-1:0]         slotActive,
  input  logic [NUM_SLOTS*PSEL_W-1:0]  slotPage,
  input  logic [NUM_SLOTS*OFF_W-1:0]   slotOffset,
  input  logic [NUM_SLOTS*LEN_W-1:0]   slotLen,
  input  logic [NUM_PAGES*PTR_W-1:0]   pagePtr,
  input  ctrlStrb_t                    strb,
  output logic                         selActive,
  output logic [LEN_W-1:0]             selLen,
  output logic                         selPageOk,
  output logic                         atPageEnd,
  output logic                         atLastPage,
  output logic [ADDR_W-1:0]            addr
);
  localparam logic [OFF_W-1:0]  OFF_MAX   = '1;
  localparam logic [PSEL_W-1:0] LAST_PAGE = PSEL_W'(NUM_PAGES - 1);

  logic [PSEL_W-1:0] pageArr [NUM_SLOTS];
  logic [OFF_W-1:0]  offArr  [NUM_SLOTS];
  logic [LEN_W-1:0]  lenArr  [NUM_SLOTS];
  logic [PTR_W-1:0]  ptrArr  [NUM_PAGES];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    assign pageArr[s] = slotPage[s*PSEL_W +: PSEL_W];
    assign offArr[s]  = slotOffset[s*OFF_W +: OFF_W];
    assign lenArr[s]  = slotLen[s*LEN_W +: LEN_W];
  end
  for (genvar p = 0; p < NUM_PAGES; p++) begin : gPtr
    assign ptrArr[p] = pagePtr[p*PTR_W +: PTR_W];
  end

  // Only the low frame bits select a slot; the rest are deliberately dropped.
  logic [SLOT_W-1:0] slotSel;
  logic              unusedFrameHigh;
  assign slotSel         = frameIdx[SLOT_W-1:0];
  assign unusedFrameHigh = ^frameIdx[FRAME_W-1:SLOT_W];

  logic [PSEL_W-1:0] selPage;
  logic [OFF_W-1:0]  selOffset;
  assign selActive = slotActive[slotSel];
  assign selPage   = pageArr[slotSel];
  assign selOffset = offArr[slotSel];
  assign selLen    = lenArr[slotSel];
  assign selPageOk = (int'(selPage) < NUM_PAGES);

  logic [PSEL_W-1:0] pageIdx;
  logic [OFF_W-1:0]  offsetReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pageIdx   <= '0;
      offsetReg <= '0;
    end else if (strb.load) begin
      pageIdx   <= selPage;
      offsetReg <= selOffset;
    end else if (strb.step) begin
      if (offsetReg == OFF_MAX) begin
        offsetReg <= '0;
        pageIdx   <= pageIdx + 1'b1;
      end else begin
        offsetReg <= offsetReg + 1'b1;
      end
    end
  end

  assign atPageEnd  = (offsetReg == OFF_MAX);
  assign atLastPage = (pageIdx == LAST_PAGE);

  // Pointer mux written as a compare loop so an unused selector code reads 0.
  logic [PTR_W-1:0] curPtr;
  always_comb begin
    curPtr = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (int'(pageIdx) == p) curPtr = ptrArr[p];
    end
  end

  assign addr = {curPtr, offsetReg};
endmodule

// File: rtl/iso_addr_ctrl.sv
module iso_addr_ctrl
  import iso_addr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             advance,
  input  logic             selActive,
  input  logic [LEN_W-1:0] selLen,
  input  logic             selPageOk,
  input  logic             atPageEnd,
  input  logic             atLastPage,
  output ctrlStrb_t        strb,
  output logic             xferActive,
  output logic             xferDone,
  output logic             xferError
);
  logic             running;
  logic             doneFlag;
  logic             errFlag;
  logic [LEN_W-1:0] byteCnt;
  logic [LEN_W-1:0] lenReg;

  logic startOk;
  logic advGo;
  logic lastByte;
  logic wrapBad;

  always_comb begin
    startOk   = startReq && selActive;
    advGo     = advance && running && !startOk;
    lastByte  = ((byteCnt + LEN_W'(1)) == lenReg);
    wrapBad   = atPageEnd && atLastPage;
    strb.load = startOk && selPageOk;
    strb.step = advGo && !lastByte && !wrapBad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      byteCnt  <= '0;
      lenReg   <= '0;
    end else if (startOk) begin
      if (selPageOk) begin
        running  <= (selLen != '0);
        doneFlag <= (selLen == '0);
        errFlag  <= 1'b0;
        byteCnt  <= '0;
        lenReg   <= selLen;
      end else begin
        running  <= 1'b0;
        doneFlag <= 1'b0;
        errFlag  <= 1'b1;
      end
    end else if (advGo) begin
      if (lastByte) begin
        running  <= 1'b0;
        doneFlag <= 1'b1;
      end else if (wrapBad) begin
        running  <= 1'b0;
        errFlag  <= 1'b1;
      end else begin
        byteCnt  <= byteCnt + 1'b1;
      end
    end
  end

  assign xferActive = running;
  assign xferDone   = doneFlag;
  assign xferError  = errFlag;
endmodule

// File: rtl/iso_addr_gen.sv
module iso_addr_gen
  import iso_addr_pkg::*;
#(
  parameter int FRAME_W   = 11,
  parameter int SLOT_W    = 3,
  parameter int NUM_PAGES = 7,
  parameter int PSEL_W    = 3,
  parameter int OFF_W     = 12,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 32,
  localparam int NUM_SLOTS = 1 << SLOT_W,
  localparam int PTR_W     = ADDR_W - OFF_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [FRAME_W-1:0]          frameIdx,
  input  logic [NUM_SLOTS-1:0]        slotActive,
  input  logic [NUM_SLOTS*PSEL_W-1:0] slotPage,
  input  logic [NUM_SLOTS*OFF_W-1:0]  slotOffset,
  input  logic [NUM_SLOTS*LEN_W-1:0]  slotLen,
  input  logic [NUM_PAGES*PTR_W-1:0]  pagePtr,
  input  logic                        startReq,
  input  logic                        advance,
  output logic [ADDR_W-1:0]           addr,
  output logic                        xferActive,
  output logic                        xferDone,
  output logic                        xferError
);
  ctrlStrb_t        strb;
  logic             selActive;
  logic [LEN_W-1:0] selLen;
  logic             selPageOk;
  logic             atPageEnd;
  logic             atLastPage;

  iso_addr_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .advance    (advance),
    .selActive  (selActive),
    .selLen     (selLen),
    .selPageOk  (selPageOk),
    .atPageEnd  (atPageEnd),
    .atLastPage (atLastPage),
    .strb       (strb),
    .xferActive (xferActive),
    .xferDone   (xferDone),
    .xferError  (xferError)
  );

  iso_addr_path #(
    .FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .NUM_PAGES(NUM_PAGES), .PSEL_W(PSEL_W),
    .OFF_W(OFF_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .frameIdx   (frameIdx),
    .slotActive (slotActive),
    .slotPage   (slotPage),
    .slotOffset (slotOffset),
    .slotLen    (slotLen),
    .pagePtr    (pagePtr),
    .strb       (strb),
    .selActive  (selActive),
    .selLen     (selLen),
    .selPageOk  (selPageOk),
    .atPageEnd  (atPageEnd),
    .atLastPage (atLastPage),
    .addr       (addr)
  );
endmodule

// File: rtl/iso_addr_gen_chk.sv
module iso_addr_gen_chk #(
  parameter int FRAME_W   = 11,
  parameter int SLOT_W    = 3,
  parameter int OFF_W     = 12,
  parameter int ADDR_W    = 32,
  localparam int NUM_SLOTS = 1 << SLOT_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [FRAME_W-1:0]   frameIdx,
  input logic [NUM_SLOTS-1:0] slotActive,
  input logic                 startReq,
  input logic                 advance,
  input logic [ADDR_W-1:0]    addr,
  input logic                 xferActive,
  input logic                 xferDone,
  input logic                 xferError
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!xferActive && !xferDone && !xferError)); // R1

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (xferActive && advance && !startReq && addr[OFF_W-1:0] != OFF_MAX)
    |=> (addr[OFF_W-1:0] == $past(addr[OFF_W-1:0]) + 1'b1) || xferDone); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (xferActive && advance && !startReq && addr[OFF_W-1:0] == OFF_MAX)
    |=> (addr[OFF_W-1:0] == '0) || xferDone || xferError); // R5

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    xferError |-> !xferActive && !xferDone); // R6

  AST_INACTIVE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (startReq && !slotActive[frameIdx[SLOT_W-1:0]] && !advance)
    |=> ($stable(xferActive) && $stable(xferDone) && $stable(xferError))); // R7

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    xferDone |-> !xferActive); // R9

  AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!xferActive && !startReq && advance)
    |=> ($stable(xferDone) && $stable(xferError) && $stable(addr[OFF_W-1:0]))); // R11
endmodule

bind iso_addr_gen iso_addr_gen_chk #(
  .FRAME_W(FRAME_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .frameIdx   (frameIdx),
  .slotActive (slotActive),
  .startReq   (startReq),
  .advance    (advance),
  .addr       (addr),
  .xferActive (xferActive),
  .xferDone   (xferDone),
  .xferError  (xferError)
);

// File: tb/iso_addr_gen_test.sv
`timescale 1ns/1ps
module iso_addr_gen_test;
  logic         clk = 1'b0;
  logic         rst;
  logic [10:0]  frameIdx;
  logic [7:0]   slotActive;
  logic [23:0]  slotPage;
  logic [95:0]  slotOffset;
  logic [95:0]  slotLen;
  logic [139:0] pagePtr;
  logic         startReq;
  logic         advance;
  logic [31:0]  addr;
  logic         xferActive;
  logic         xferDone;
  logic         xferError;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  iso_addr_gen uut (
    .clk(clk), .rst(rst), .frameIdx(frameIdx), .slotActive(slotActive),
    .slotPage(slotPage), .slotOffset(slotOffset), .slotLen(slotLen),
    .pagePtr(pagePtr), .startReq(startReq), .advance(advance),
    .addr(addr), .xferActive(xferActive), .xferDone(xferDone),
    .xferError(xferError)
  );

  function automatic logic [19:0] ptrVal(int i);
    return 20'hA0000 + 20'(i) * 20'h01111;
  endfunction

  function automatic logic [31:0] expAddr(int page, logic [11:0] off);
    return {ptrVal(page), off};
  endfunction

  // Slot k: page selector k, offsets and lengths below; slot 5 inactive.
  localparam logic [11:0] OFFS [8] = '{12'h010, 12'h234, 12'hFFE, 12'h400,
                                       12'h7FF, 12'h500, 12'hFFD, 12'h000};
  localparam logic [11:0] LENS [8] = '{12'd4, 12'd4, 12'd5, 12'd0,
                                       12'd4, 12'd4, 12'd10, 12'd4};

  // Vector: frame index, expected active, expected done.
  localparam int NVEC = 6;
  localparam logic [12:0] VEC [NVEC] = '{
    {11'h000, 1'b1, 1'b0},
    {11'h009, 1'b1, 1'b0},
    {11'h7F2, 1'b1, 1'b0},
    {11'h003, 1'b0, 1'b1},
    {11'h00C, 1'b1, 1'b0},
    {11'h0AE, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(string req, logic a, logic d, logic e);
    check(req, {29'b0, xferActive, xferDone, xferError}, {29'b0, a, d, e});
  endtask

  task automatic startAt(logic [10:0] fi);
    @(negedge clk);
    frameIdx = fi;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; frameIdx = '0; startReq = 1'b0; advance = 1'b0;
    slotActive = 8'hDF;
    for (int k = 0; k < 8; k++) begin
      slotPage[3*k +: 3]    = 3'(k);
      slotOffset[12*k +: 12] = OFFS[k];
      slotLen[12*k +: 12]    = LENS[k];
    end
    for (int p = 0; p < 7; p++) pagePtr[20*p +: 20] = ptrVal(p);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    checkFlags("R1 flags", 1'b0, 1'b0, 1'b0);
    check("R1 addr", addr, expAddr(0, 12'h000));

    // R11: advance while idle
    adv(2);
    checkFlags("R11 flags", 1'b0, 1'b0, 1'b0);
    check("R11 addr", addr, expAddr(0, 12'h000));

    // R2/R3/R10: table of start vectors
    for (int v = 0; v < NVEC; v++) begin
      automatic int slot = int'(VEC[v][4:2]);
      startAt(VEC[v][12:2]);
      check("R2 R3 addr", addr, expAddr(slot, OFFS[slot]));
      checkFlags("R3 R10 flags", VEC[v][1], VEC[v][0], 1'b0);
    end

    // R4 and R9: slot 0, length 4
    startAt(11'h000);
    adv(3);
    check("R4 addr", addr, expAddr(0, 12'h013));
    checkFlags("R4 flags", 1'b1, 1'b0, 1'b0);
    adv(1);
    check("R9 addr hold", addr, expAddr(0, 12'h013));
    checkFlags("R9 done", 1'b0, 1'b1, 1'b0);
    adv(2);
    check("R9 extra addr", addr, expAddr(0, 12'h013));
    checkFlags("R9 extra flags", 1'b0, 1'b1, 1'b0);

    // R5: page crossing from slot 2
    startAt(11'h002);
    adv(1);
    check("R5 pre", addr, expAddr(2, 12'hFFF));
    adv(1);
    check("R5 cross", addr, expAddr(3, 12'h000));
    adv(1);
    check("R5 post", addr, expAddr(3, 12'h001));

    // R6: overrun past pointer 6
    startAt(11'h006);
    adv(2);
    check("R6 pre", addr, expAddr(6, 12'hFFF));
    adv(1);
    checkFlags("R6 flags", 1'b0, 1'b0, 1'b1);
    check("R6 addr", addr, expAddr(6, 12'hFFF));
    adv(1);
    check("R6 held", addr, expAddr(6, 12'hFFF));

    // R12: restart clears error
    startAt(11'h000);
    checkFlags("R12 flags", 1'b1, 1'b0, 1'b0);
    check("R12 addr", addr, expAddr(0, 12'h010));

    // R7: inactive slot start mid-transfer
    adv(1);
    startAt(11'h005);
    check("R7 addr", addr, expAddr(0, 12'h011));
    checkFlags("R7 flags", 1'b1, 1'b0, 1'b0);

    // R8: page selector 7
    startAt(11'h007);
    checkFlags("R8 flags", 1'b0, 1'b0, 1'b1);

    // R12: restart onto zero-length slot clears error
    startAt(11'h003);
    checkFlags("R12 done", 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule